// File: doc/BRIEF.md
# Banked Internal Data Memory Decoder

This block holds a 256-byte scratchpad RAM and decides, for every data access, which storage the access reaches and at which byte and bit. Each request carries an 8-bit address and one of four access modes: direct, indirect, register-name and bit. The low half of the address space is always scratchpad RAM. The high half reaches either the upper half of the RAM or an external special-register file, and the access mode decides which one.

Register-name accesses use a 3-bit register number. The number is placed inside one of four banks of eight bytes, chosen by a 2-bit bank-select input. The surrounding core feeds that input from two bits of its status word. Bit accesses name one of 128 bits in a 16-byte window of RAM, or one bit of an eight-aligned special register. Bit writes are done as a read-modify-write within a single cycle. The special-register file itself stays outside: the block drives an address, a strobe, a write flag and write data, and takes the read data back in the same cycle.

Top module: `dmem_decoder`

## Requirements
- R1: After reset no response is pending and every RAM byte reads 00h.
- R2: A read request (req_write low) gives exactly one response, rsp_valid high, on the cycle after it is accepted. A write request gives none. Data written in one cycle is visible to a read in the next cycle.
- R3: Addresses 00h–7Fh reach the same RAM byte in direct mode (req_mode 0) and in indirect mode (req_mode 1).
- R4: In indirect mode, addresses 80h–FFh reach the upper 128 RAM bytes, and the special-register port stays idle.
- R5: A direct access to a defined special-register address goes to the special-register port. The defined addresses are 80h–83h, 87h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h and F0h. A read returns sfr_rdata, and a write presents req_wdata with sfr_write high.
- R6: A direct read of any other address in 80h–FFh returns 00h. A direct write to such an address changes nothing and leaves the special-register port idle.
- R7: In register mode (req_mode 2), req_addr[2:0] selects register n, and the access reaches RAM byte bank_sel×8 + n.
- R8: In bit mode (req_mode 3), a bit address b below 80h maps to RAM byte 20h + (b>>3), bit b&7. A write sets that bit to req_wdata[0] and leaves the other seven bits unchanged. A read returns the bit in rsp_rdata[0], with bits 7:1 at zero.
- R9: A byte write to a bit-addressable byte replaces any bits that earlier bit writes set or cleared in it.
- R10: In bit mode, a bit address b of 80h or above selects byte b&F8h, bit b&7. If that byte is a defined special register, the access goes to the special-register port: a bit write writes back the merged byte, and a bit read returns the selected bit. If the byte is not defined, a read returns 00h and a write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 register-name, 3 bit |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Write byte; bit value in bit 0 for bit mode |
| bank_sel | input | 2 | Active register bank |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 8 | Read response data |
| sfr_valid | output | 1 | Special-register port strobe |
| sfr_write | output | 1 | Special-register write |
| sfr_addr | output | 8 | Special-register address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, same cycle |

## Verification
The assertions assume that sfr_rdata is a combinational function of sfr_addr, valid in the same cycle as the strobe. They also assume that req_mode and req_addr are stable while req_valid is high within a cycle. The bench keeps to both. Its special-register model reads from an array indexed by sfr_addr and commits writes at the clock edge, and it drives every request at the falling edge. bank_sel is taken from bits 4:3 of the modelled status register at D0h, so bank changes always come through a direct write one cycle earlier.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'd0,
        MODE_INDIRECT = 2'd1,
        MODE_REG      = 2'd2,
        MODE_BIT      = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_SFR  = 2'd2
    } target_e;

    // Direct addresses that hold an implemented special register.
    function automatic logic sfr_is_defined(input logic [ADDR_W-1:0] a);
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h87,
            8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D,
            8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8,
            8'hB0, 8'hB8, 8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dmem_route.sv
module dmem_route
    import dmem_pkg::*;
#(
    parameter int unsigned           REGS_PER_BANK = 8,
    parameter int unsigned           BANK_W        = 2,
    parameter logic [ADDR_W-1:0]     BIT_BASE      = 8'h20
) (
    input  acc_mode_e                 mode,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BANK_W-1:0]         bank,
    output target_e                   tgt,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic                      is_bit
);
    localparam int unsigned REG_W = $clog2(REGS_PER_BANK);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam int unsigned MSB   = ADDR_W - 1;

    logic [ADDR_W-1:0] aligned_addr;
    logic [ADDR_W-1:0] bit_byte_addr;

    always_comb begin
        aligned_addr  = {addr[MSB:IDX_W], {IDX_W{1'b0}}};
        bit_byte_addr = BIT_BASE + ADDR_W'(addr[MSB-1:IDX_W]);
    end

    always_comb begin
        tgt       = TGT_NONE;
        byte_addr = addr;
        bit_idx   = '0;
        is_bit    = 1'b0;
        unique case (mode)
            MODE_DIRECT: begin
                if (!addr[MSB]) begin
                    tgt = TGT_RAM;
                end else if (sfr_is_defined(addr)) begin
                    tgt = TGT_SFR;
                end
            end
            MODE_INDIRECT: begin
                tgt = TGT_RAM;
            end
            MODE_REG: begin
                tgt       = TGT_RAM;
                byte_addr = ADDR_W'({bank, addr[REG_W-1:0]});
            end
            MODE_BIT: begin
                is_bit  = 1'b1;
                bit_idx = addr[IDX_W-1:0];
                if (!addr[MSB]) begin
                    tgt       = TGT_RAM;
                    byte_addr = bit_byte_addr;
                end else begin
                    byte_addr = aligned_addr;
                    if (sfr_is_defined(aligned_addr)) begin
                        tgt = TGT_SFR;
                    end
                end
            end
            default: tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/dmem_bit_merge.sv
module dmem_bit_merge #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0]         cur,
    input  logic [$clog2(DATA_W)-1:0] idx,
    input  logic                      val,
    output logic [DATA_W-1:0]         merged,
    output logic                      picked
);
    always_comb begin
        merged      = cur;
        merged[idx] = val;
        picked      = cur[idx];
    end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_comb begin
        rdata = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/dmem_decoder.sv
module dmem_decoder
    import dmem_pkg::*;
#(
    parameter int unsigned       RAM_BYTES     = 256,
    parameter int unsigned       REGS_PER_BANK = 8,
    parameter int unsigned       BANK_W        = 2,
    parameter logic [7:0]        BIT_BASE      = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_mode,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    input  logic [1:0] bank_sel,
    output logic       rsp_valid,
    output logic [7:0] rsp_rdata,
    output logic       sfr_valid,
    output logic       sfr_write,
    output logic [7:0] sfr_addr,
    output logic [7:0] sfr_wdata,
    input  logic [7:0] sfr_rdata
);
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam int unsigned RAM_AW = $clog2(RAM_BYTES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    target_e           tgt;
    logic [ADDR_W-1:0] byte_addr;
    logic [IDX_W-1:0]  bit_idx;
    logic              is_bit;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] cur_byte;
    logic [DATA_W-1:0] merged;
    logic              picked;
    logic [DATA_W-1:0] store_byte;
    logic              ram_we;

    dmem_route #(
        .REGS_PER_BANK (REGS_PER_BANK),
        .BANK_W        (BANK_W),
        .BIT_BASE      (BIT_BASE)
    ) route_i (
        .mode      (acc_mode_e'(req_mode)),
        .addr      (req_addr),
        .bank      (bank_sel),
        .tgt       (tgt),
        .byte_addr (byte_addr),
        .bit_idx   (bit_idx),
        .is_bit    (is_bit)
    );

    dmem_ram #(
        .DEPTH  (RAM_BYTES),
        .DATA_W (DATA_W)
    ) ram_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (RAM_AW'(byte_addr)),
        .wdata (store_byte),
        .rdata (ram_rdata)
    );

    dmem_bit_merge #(
        .DATA_W (DATA_W)
    ) merge_i (
        .cur    (cur_byte),
        .idx    (bit_idx),
        .val    (req_wdata[0]),
        .merged (merged),
        .picked (picked)
    );

    always_comb begin
        cur_byte   = (tgt == TGT_SFR) ? sfr_rdata : ram_rdata;
        store_byte = is_bit ? merged : req_wdata;
        ram_we     = req_valid && req_write && (tgt == TGT_RAM);
        sfr_valid  = req_valid && (tgt == TGT_SFR);
        sfr_write  = sfr_valid && req_write;
        sfr_addr   = byte_addr;
        sfr_wdata  = store_byte;
    end

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = '0;
        if (req_valid && !req_write && (tgt != TGT_NONE)) begin
            rsp_d.data = is_bit ? DATA_W'(picked) : cur_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/dmem_decoder_chk.sv
module dmem_decoder_chk
    import dmem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic [1:0] req_mode,
    input logic [7:0] req_addr,
    input logic       rsp_valid,
    input logic [7:0] rsp_rdata,
    input logic       sfr_valid,
    input logic       sfr_write,
    input logic [7:0] sfr_addr,
    input logic [7:0] sfr_wdata,
    input logic [7:0] sfr_rdata
);
    logic rd_req;
    logic undef_direct;

    always_comb begin
        rd_req       = req_valid && !req_write;
        undef_direct = req_valid && (req_mode == 2'd0) && req_addr[7]
                       && !sfr_is_defined(req_addr);
    end

    a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);

    a_r4_indirect_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd1) |-> !sfr_valid);

    a_r7_regname_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd2) |-> !sfr_valid);

    a_r5_port_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_valid |-> sfr_addr[7]);

    a_r5_read_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_mode == 2'd0 && sfr_valid) |=> rsp_rdata == $past(sfr_rdata));

    a_r6_undef_port_idle: assert property (@(posedge clk) disable iff (!rst_n)
        undef_direct |-> !sfr_valid);

    a_r6_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_direct && !req_write) |=> rsp_rdata == 8'h00);

    a_r8_bit_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_mode == 2'd3) |=> rsp_rdata[7:1] == 7'd0);

    a_r10_bit_port_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_valid && req_mode == 2'd3) |-> sfr_addr[2:0] == 3'd0);

    a_r10_bit_port_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_write && req_mode == 2'd3) |-> $countones(sfr_wdata ^ sfr_rdata) <= 1);

endmodule

bind dmem_decoder dmem_decoder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mode  (req_mode),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .sfr_valid (sfr_valid),
    .sfr_write (sfr_write),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata)
);

// File: tb/dmem_decoder_tb_top.sv
`timescale 1ns/1ps
module dmem_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic [1:0] bank_sel;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       sfr_valid;
    logic       sfr_write;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    logic [7:0] sfr_mem [256];
    int         sfr_hits = 0;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    localparam logic [1:0] M_DIR = 2'd0;
    localparam logic [1:0] M_IND = 2'd1;
    localparam logic [1:0] M_REG = 2'd2;
    localparam logic [1:0] M_BIT = 2'd3;

    always #4 clk = ~clk;

    assign sfr_rdata = sfr_mem[sfr_addr];
    assign bank_sel  = sfr_mem[8'hD0][4:3];

    always @(posedge clk) begin
        if (rst_n && sfr_valid) begin
            sfr_hits <= sfr_hits + 1;
            if (sfr_write) sfr_mem[sfr_addr] <= sfr_wdata;
        end
    end

    dmem_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mode  (req_mode),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bank_sel  (bank_sel),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sfr_valid (sfr_valid),
        .sfr_write (sfr_write),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] m, input logic [7:0] a, input logic w,
                      input logic [7:0] wd, input logic [7:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_mode  = m;
        req_addr  = a;
        req_wdata = wd;
        if (!w) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [1:0] m, input logic [7:0] a, input logic [7:0] wd);
        op(m, a, 1'b1, wd, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] m, input logic [7:0] a, input logic [7:0] exp,
                      input string tag);
        op(m, a, 1'b0, 8'h00, exp, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Scoreboard monitor: each response pops the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected response actual=%02h expected=none", rsp_rdata);
            end else begin
                check8(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hits0;
        for (int i = 0; i < 256; i++) sfr_mem[i] = 8'h00;
        sfr_mem[8'h90] = 8'h11;
        sfr_mem[8'hC0] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rsp_valid actual=%0b expected=0", rsp_valid);
        end
        rd(M_IND, 8'h55, 8'h00, "R1 ram cleared 55h");
        rd(M_DIR, 8'h10, 8'h00, "R1 ram cleared 10h");

        // R3 lower half shared by direct and indirect
        wr(M_DIR, 8'h30, 8'hA5);
        rd(M_IND, 8'h30, 8'hA5, "R3 direct write, indirect read");
        wr(M_IND, 8'h7F, 8'h3C);
        rd(M_DIR, 8'h7F, 8'h3C, "R3 indirect write, direct read");
        idle();

        // R4 / R5 upper half steering
        hits0 = sfr_hits;
        wr(M_IND, 8'h90, 8'h77);
        idle();
        check8(8'(sfr_hits - hits0), 8'h00, "R4 indirect write keeps port idle");
        rd(M_IND, 8'h90, 8'h77, "R4 indirect read of upper RAM");
        rd(M_DIR, 8'h90, 8'h11, "R5 direct read of special register");
        wr(M_DIR, 8'h90, 8'h5A);
        idle();
        check8(sfr_mem[8'h90], 8'h5A, "R5 direct write reaches port");
        rd(M_IND, 8'h90, 8'h77, "R4 upper RAM untouched by direct write");
        idle();

        // R6 undefined special-register address
        hits0 = sfr_hits;
        rd(M_DIR, 8'hC0, 8'h00, "R6 undefined direct read");
        wr(M_DIR, 8'hC0, 8'h12);
        idle();
        check8(8'(sfr_hits - hits0), 8'h00, "R6 undefined access keeps port idle");
        check8(sfr_mem[8'hC0], 8'hEE, "R6 undefined write ignored");

        // R7 register-name banking through the status register
        wr(M_DIR, 8'hD0, 8'h10);
        wr(M_REG, 8'h04, 8'h9C);
        rd(M_IND, 8'h14, 8'h9C, "R7 bank 2 register 4 at 14h");
        wr(M_DIR, 8'hD0, 8'h18);
        wr(M_REG, 8'h07, 8'h4B);
        rd(M_IND, 8'h1F, 8'h4B, "R7 bank 3 register 7 at 1Fh");
        rd(M_REG, 8'h07, 8'h4B, "R7 register read in bank 3");
        wr(M_DIR, 8'hD0, 8'h00);
        rd(M_REG, 8'h07, 8'h00, "R7 register 7 in bank 0 at 07h");

        // R8 bit-addressable RAM
        wr(M_DIR, 8'h21, 8'h00);
        wr(M_BIT, 8'h09, 8'h01);
        rd(M_DIR, 8'h21, 8'h02, "R8 set bit 09h gives 21h=02h");
        rd(M_BIT, 8'h09, 8'h01, "R8 bit read of set bit");
        rd(M_BIT, 8'h08, 8'h00, "R8 bit read of clear neighbour");
        wr(M_BIT, 8'h7F, 8'h01);
        rd(M_DIR, 8'h2F, 8'h80, "R8 top bit address 7Fh");
        wr(M_DIR, 8'h22, 8'hFF);
        wr(M_BIT, 8'h12, 8'h00);
        rd(M_IND, 8'h22, 8'hFB, "R8 clear keeps other bits");

        // R9 byte write overrides bit state
        wr(M_BIT, 8'h09, 8'h01);
        wr(M_DIR, 8'h21, 8'hF4);
        rd(M_DIR, 8'h21, 8'hF4, "R9 byte write after bit set");
        rd(M_BIT, 8'h09, 8'h00, "R9 bit lost after byte write");

        // R10 bit access to special registers
        wr(M_BIT, 8'h8B, 8'h01);
        idle();
        check8(sfr_mem[8'h88], 8'h08, "R10 bit set in register 88h");
        rd(M_BIT, 8'h8B, 8'h01, "R10 bit read from register 88h");
        wr(M_BIT, 8'hE7, 8'h01);
        idle();
        check8(sfr_mem[8'hE0], 8'h80, "R10 bit set in register E0h");
        hits0 = sfr_hits;
        wr(M_BIT, 8'hC9, 8'h01);
        rd(M_BIT, 8'hC9, 8'h00, "R10 undefined bit read");
        idle();
        check8(8'(sfr_hits - hits0), 8'h00, "R10 undefined bit access no effect");
        check8(sfr_mem[8'hC8], 8'h00, "R10 undefined byte unchanged");

        repeat (4) idle();
        check8(8'(exp_q.size()), 8'h00, "R2 all reads answered");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule